// File: doc/BRIEF.md
# Eye-Map Health Feature Extractor

This block examines a finished two-dimensional bit-error map of a monitored link. The map has 32 sampling-phase columns and 127 decision-threshold rows, and each point holds an error count. After a start pulse the block reads every point once through a simple synchronous read port. It then reports four health features: the number of error-free phases on the middle threshold row, the tallest error-free run counted per column, the total number of error-free points, and the sum of all error counts.

A capture command stores the reported error-free point count as the healthy baseline. At the end of each later analysis, the block compares the new point count with that baseline. It raises a failure flag when the eye has shrunk by more than one fifth. The flag and the features hold their values until the next analysis finishes.

Control is a four-state machine. IDLE waits for `start` (IDLE->SCAN, clearing the accumulators). SCAN issues one read per cycle and moves to DRAIN after the last address. DRAIN absorbs the final returned word and moves to LATCH. LATCH copies the results to the outputs, updates the flag, and returns to IDLE, with `done` high in the following cycle.

Top module: `eye_health_detector`

## Requirements
- R1: After `start` in IDLE, `rd_en` is high for exactly 4064 consecutive cycles. It presents column-major addresses: `rd_v` steps 0..126 within each `rd_t` value, and `rd_t` steps 0..31. `rd_data` for an address is sampled one cycle after that address is presented.
- R2: `busy` is high from the cycle after `start` until the analysis ends. `done` is a single-cycle pulse that marks the cycle in which new results first appear.
- R3: A point counts as open when its error count is zero. `eye_size` is the number of open points in the whole map.
- R4: `eye_width` is the number of columns whose point on the middle row (`rd_v` = 63) is open.
- R5: `eye_height` is the largest number of open points found in any single column.
- R6: `err_total` is the exact sum of all 4064 error counts, with no overflow even when every count is at its maximum of 65535.
- R7: A `capture` pulse stores the value currently on `eye_size` as the baseline. The baseline is zero after reset.
- R8: At the end of each analysis, `fail_flag` becomes 1 when 5·`eye_size` < 4·baseline and 0 otherwise. An eye at exactly 80 % of the baseline passes.
- R9: `fail_flag` and all feature outputs change only at the end of an analysis. A `capture` leaves them unchanged.
- R10: During reset and right after it, `busy`, `done`, `rd_en`, `fail_flag` and all feature outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an analysis (used in IDLE) |
| busy | output | 1 | Analysis in progress |
| done | output | 1 | One-cycle pulse when results update |
| rd_en | output | 1 | Map read strobe |
| rd_t | output | 5 | Sampling-phase column address |
| rd_v | output | 7 | Threshold row address |
| rd_data | input | 16 | Error count returned one cycle after the address |
| capture | input | 1 | Store current `eye_size` as baseline |
| eye_width | output | 6 | Open columns on the middle row |
| eye_height | output | 7 | Largest open count in one column |
| eye_size | output | 12 | Open points in the map |
| err_total | output | 28 | Sum of all error counts |
| fail_flag | output | 1 | Eye shrunk below 80 % of baseline |

## Verification
The bench runs the block on several maps. A fully open map gives the maximum of every geometry feature. A centred rectangular eye separates width, which depends only on the middle row, from height and size. A scattered diagonal pattern gives columns with unequal open counts, so the column maximum has to pick the right column. Maps that are open for exactly the first N points straddle the 80 % threshold at 800 and 799 open points. A saturated map with every count at 65535 exercises the error-sum width and an eye of zero. A capture issued between analyses shows that the flag and the features hold their values.

// File: rtl/eyemap_pkg.sv
package eyemap_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_SCAN  = 2'd1,
        S_DRAIN = 2'd2,
        S_LATCH = 2'd3
    } scan_state_t;
endpackage

// File: rtl/eyemap_scan.sv
module eyemap_scan #(
    parameter int NT = 32,
    parameter int NV = 127,
    localparam int TW = $clog2(NT),
    localparam int VW = $clog2(NV)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    output logic [TW-1:0] t_idx,
    output logic [VW-1:0] v_idx,
    output logic          col_end,
    output logic          last
);
    assign col_end = (v_idx == VW'(NV - 1));
    assign last    = col_end && (t_idx == TW'(NT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_idx <= '0;
            v_idx <= '0;
        end else if (clr) begin
            t_idx <= '0;
            v_idx <= '0;
        end else if (step) begin
            if (col_end) begin
                v_idx <= '0;
                t_idx <= t_idx + TW'(1);
            end else begin
                v_idx <= v_idx + VW'(1);
            end
        end
    end
endmodule

// File: rtl/eyemap_accum.sv
module eyemap_accum #(
    parameter int NT = 32,
    parameter int NV = 127,
    parameter int CW = 16,
    localparam int WW = $clog2(NT + 1),
    localparam int HW = $clog2(NV + 1),
    localparam int SW = $clog2(NT * NV + 1),
    localparam int EW = CW + SW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          vld,
    input  logic [CW-1:0] data,
    input  logic          at_mid,
    input  logic          col_end,
    output logic [WW-1:0] width,
    output logic [HW-1:0] height,
    output logic [SW-1:0] size,
    output logic [EW-1:0] sum
);
    logic          open_pt;
    logic [HW-1:0] col_cnt;
    logic [HW-1:0] col_next;

    assign open_pt  = (data == '0);
    assign col_next = col_cnt + HW'(open_pt);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            width   <= '0;
            height  <= '0;
            size    <= '0;
            sum     <= '0;
            col_cnt <= '0;
        end else if (clr) begin
            width   <= '0;
            height  <= '0;
            size    <= '0;
            sum     <= '0;
            col_cnt <= '0;
        end else if (vld) begin
            size <= size + SW'(open_pt);
            sum  <= sum + EW'(data);
            if (at_mid && open_pt)
                width <= width + WW'(1);
            if (col_end) begin
                col_cnt <= '0;
                if (col_next > height)
                    height <= col_next;
            end else begin
                col_cnt <= col_next;
            end
        end
    end
endmodule

// File: rtl/eyemap_health.sv
module eyemap_health #(
    parameter int SW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [SW-1:0] size_shown,
    input  logic          upd,
    input  logic [SW-1:0] size_new,
    output logic          fail
);
    localparam int MW = SW + 3;

    logic [SW-1:0] baseline;
    logic [MW-1:0] shrunk;
    logic [MW-1:0] limit;

    assign shrunk = MW'(size_new) * MW'(5);
    assign limit  = MW'(baseline) * MW'(4);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            baseline <= '0;
            fail     <= 1'b0;
        end else begin
            if (capture)
                baseline <= size_shown;
            if (upd)
                fail <= (shrunk < limit);
        end
    end
endmodule

// File: rtl/eye_health_detector.sv
module eye_health_detector #(
    parameter int NT = 32,
    parameter int NV = 127,
    parameter int CW = 16,
    localparam int TW  = $clog2(NT),
    localparam int VW  = $clog2(NV),
    localparam int WW  = $clog2(NT + 1),
    localparam int HW  = $clog2(NV + 1),
    localparam int SW  = $clog2(NT * NV + 1),
    localparam int EW  = CW + SW,
    localparam int MID = NV / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          busy,
    output logic          done,
    output logic          rd_en,
    output logic [TW-1:0] rd_t,
    output logic [VW-1:0] rd_v,
    input  logic [CW-1:0] rd_data,
    input  logic          capture,
    output logic [WW-1:0] eye_width,
    output logic [HW-1:0] eye_height,
    output logic [SW-1:0] eye_size,
    output logic [EW-1:0] err_total,
    output logic          fail_flag
);
    import eyemap_pkg::*;

    scan_state_t state, state_nx;

    logic          clr, step, col_end, last;
    logic          vld_q, mid_q, cend_q;
    logic [WW-1:0] acc_w;
    logic [HW-1:0] acc_h;
    logic [SW-1:0] acc_s;
    logic [EW-1:0] acc_e;

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (start) state_nx = S_SCAN;
            S_SCAN:  if (last)  state_nx = S_DRAIN;
            S_DRAIN: state_nx = S_LATCH;
            S_LATCH: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    assign clr   = (state == S_IDLE) && start;
    assign step  = (state == S_SCAN);
    assign rd_en = step;
    assign busy  = (state != S_IDLE);

    eyemap_scan #(.NT(NT), .NV(NV)) u_scan (
        .clk(clk), .rst_n(rst_n), .clr(clr), .step(step),
        .t_idx(rd_t), .v_idx(rd_v), .col_end(col_end), .last(last)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            mid_q  <= 1'b0;
            cend_q <= 1'b0;
        end else begin
            vld_q  <= step;
            mid_q  <= (rd_v == VW'(MID));
            cend_q <= col_end;
        end
    end

    eyemap_accum #(.NT(NT), .NV(NV), .CW(CW)) u_acc (
        .clk(clk), .rst_n(rst_n), .clr(clr), .vld(vld_q), .data(rd_data),
        .at_mid(mid_q), .col_end(cend_q),
        .width(acc_w), .height(acc_h), .size(acc_s), .sum(acc_e)
    );

    eyemap_health #(.SW(SW)) u_hlth (
        .clk(clk), .rst_n(rst_n), .capture(capture), .size_shown(eye_size),
        .upd(state == S_LATCH), .size_new(acc_s), .fail(fail_flag)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done       <= 1'b0;
            eye_width  <= '0;
            eye_height <= '0;
            eye_size   <= '0;
            err_total  <= '0;
        end else begin
            done <= (state == S_LATCH);
            if (state == S_LATCH) begin
                eye_width  <= acc_w;
                eye_height <= acc_h;
                eye_size   <= acc_s;
                err_total  <= acc_e;
            end
        end
    end
endmodule

// File: rtl/eye_health_checker.sv
module eye_health_checker #(
    parameter int NT = 32,
    parameter int NV = 127,
    parameter int TW = 5,
    parameter int VW = 7,
    parameter int WW = 6,
    parameter int HW = 7,
    parameter int SW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          rd_en,
    input logic [TW-1:0] rd_t,
    input logic [VW-1:0] rd_v,
    input logic [WW-1:0] eye_width,
    input logic [HW-1:0] eye_height,
    input logic [SW-1:0] eye_size,
    input logic          fail_flag
);
    a_r1_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (int'(rd_t) < NT && int'(rd_v) < NV));

    a_r1_read_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> busy);

    a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_flag_moves_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fail_flag) |-> done);

    a_r5_feature_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (int'(eye_width) <= NT && int'(eye_height) <= NV));

    a_r3_size_covers: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (int'(eye_size) >= int'(eye_width) && int'(eye_size) >= int'(eye_height)));
endmodule

bind eye_health_detector eye_health_checker #(
    .NT(NT), .NV(NV), .TW(TW), .VW(VW), .WW(WW), .HW(HW), .SW(SW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .rd_en(rd_en),
    .rd_t(rd_t), .rd_v(rd_v), .eye_width(eye_width), .eye_height(eye_height),
    .eye_size(eye_size), .fail_flag(fail_flag)
);

// File: tb/sim_eye_health_detector.sv
`timescale 1ns/1ps
module sim_eye_health_detector;
    localparam int NT = 32;
    localparam int NV = 127;
    localparam int NP = NT * NV;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        capture = 1'b0;
    logic        busy, done, rd_en, fail_flag;
    logic [4:0]  rd_t;
    logic [6:0]  rd_v;
    logic [15:0] rd_data = '0;
    logic [5:0]  eye_width;
    logic [6:0]  eye_height;
    logic [11:0] eye_size;
    logic [27:0] err_total;

    int mem [NP];
    int n_chk = 0;
    int n_bad = 0;
    int base_exp = 0;
    int seq_idx = 0;
    int seq_err = 0;
    logic [15:0] pend = '0;

    always #4 clk = ~clk;

    eye_health_detector u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .rd_en(rd_en), .rd_t(rd_t), .rd_v(rd_v), .rd_data(rd_data),
        .capture(capture), .eye_width(eye_width), .eye_height(eye_height),
        .eye_size(eye_size), .err_total(err_total), .fail_flag(fail_flag)
    );

    // map model: one cycle of read latency, updated away from the active edge
    always @(negedge clk) begin
        rd_data = pend;
        if (rd_en) begin
            pend = 16'(mem[int'(rd_t) * NV + int'(rd_v)]);
            if (int'(rd_t) != seq_idx / NV || int'(rd_v) != seq_idx % NV)
                seq_err++;
            seq_idx++;
        end else begin
            pend = '0;
        end
    end

    task automatic check(string req, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_size();
        int s = 0;
        for (int i = 0; i < NP; i++) if (mem[i] == 0) s++;
        return s;
    endfunction

    function automatic int exp_width();
        int w = 0;
        for (int t = 0; t < NT; t++) if (mem[t * NV + NV / 2] == 0) w++;
        return w;
    endfunction

    function automatic int exp_height();
        int h = 0;
        for (int t = 0; t < NT; t++) begin
            int c = 0;
            for (int v = 0; v < NV; v++) if (mem[t * NV + v] == 0) c++;
            if (c > h) h = c;
        end
        return h;
    endfunction

    function automatic longint exp_sum();
        longint s = 0;
        for (int i = 0; i < NP; i++) s += mem[i];
        return s;
    endfunction

    // run one analysis and check all features and the flag
    task automatic run_and_check(string tag);
        int cyc = 0;
        int sz;
        seq_idx = 0;
        seq_err = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check({tag, " R2 busy"}, busy, 1);
        while (!done && cyc < 6000) begin
            @(negedge clk); cyc++;
        end
        check({tag, " R2 done seen"}, done, 1);
        check({tag, " R1 reads"}, seq_idx, NP);
        check({tag, " R1 order"}, seq_err, 0);
        sz = exp_size();
        check({tag, " R3 size"}, eye_size, sz);
        check({tag, " R4 width"}, eye_width, exp_width());
        check({tag, " R5 height"}, eye_height, exp_height());
        check({tag, " R6 sum"}, err_total, exp_sum());
        check({tag, " R8 flag"}, fail_flag, (5 * sz < 4 * base_exp) ? 1 : 0);
        @(negedge clk);
        check({tag, " R2 done pulse"}, done, 0);
        check({tag, " R2 idle"}, busy, 0);
    endtask

    // capture baseline; flag and features must not move (R7, R9)
    task automatic do_capture(string tag);
        logic f0 = fail_flag;
        logic [11:0] s0 = eye_size;
        @(negedge clk); capture = 1'b1;
        @(negedge clk); capture = 1'b0;
        base_exp = int'(s0);
        @(negedge clk);
        check({tag, " R9 flag held"}, fail_flag, f0);
        check({tag, " R9 size held"}, eye_size, s0);
    endtask

    task automatic fill_first_n(int n, int cnt);
        for (int i = 0; i < NP; i++) mem[i] = (i < n) ? 0 : cnt;
    endtask

    task automatic t_reset();
        check("R10 busy", busy, 0);
        check("R10 done", done, 0);
        check("R10 rd_en", rd_en, 0);
        check("R10 flag", fail_flag, 0);
        check("R10 size", eye_size, 0);
        check("R10 sum", err_total, 0);
    endtask

    task automatic t_all_open();
        fill_first_n(NP, 0);
        run_and_check("all-open");
        do_capture("all-open R7");
    endtask

    task automatic t_box_eye();
        for (int t = 0; t < NT; t++)
            for (int v = 0; v < NV; v++)
                mem[t * NV + v] = (t >= 8 && t < 24 && v >= 40 && v < 91) ? 0 : 3;
        run_and_check("box");
        check("box R8 shrunk flag", fail_flag, 1);
    endtask

    task automatic t_scatter();
        for (int t = 0; t < NT; t++)
            for (int v = 0; v < NV; v++)
                mem[t * NV + v] = ((t * 3 + v * 5) % 7 == 0) ? 0 : ((t + v) % 4 + 1);
        run_and_check("scatter");
    endtask

    task automatic t_threshold();
        fill_first_n(1000, 2);
        run_and_check("n1000");
        do_capture("n1000 R7");
        fill_first_n(800, 2);
        run_and_check("n800");
        check("n800 R8 exact 80pct passes", fail_flag, 0);
        fill_first_n(799, 2);
        run_and_check("n799");
        check("n799 R8 below 80pct fails", fail_flag, 1);
    endtask

    task automatic t_saturated();
        fill_first_n(0, 65535);
        run_and_check("sat");
        check("sat R6 full sum", err_total, 64'd266334240);
        check("sat R5 height zero", eye_height, 0);
    endtask

    initial begin
        #100000000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_all_open();
        t_box_eye();
        t_scatter();
        t_threshold();
        t_saturated();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule